// File: doc/BRIEF.md
# Warp Request Coalescer

The block accepts one memory-read instruction issued by a group of lanes. Each lane carries an active bit and the byte address of a 4-byte element. The block turns the instruction into the smallest set of external read requests that covers every active lane. The fetch unit is a fixed-size sector. Every sector that any active lane touches is fetched whole.

Sectors are grouped by the aligned line that holds them. Inside a line, each unbroken run of touched sectors leaves as one request, sized from one sector up to a full line. No request ever spans two lines, so a contiguous access that starts off a line boundary always costs two requests. Lines leave in ascending address order, and runs inside a line leave in ascending sector order. The lane order of the input has no effect on this order. Requests use a valid/ready handshake. The input stays stalled until the last request of the instruction has been taken. A one-cycle done pulse then marks the end of the instruction.

With the default parameters there are 32 lanes, 32-bit addresses, 128-byte lines and 32-byte sectors. A request therefore carries 32, 64, 96 or 128 bytes, and the size is reported as a sector count from 1 to 4.

Top module: `warp_coalescer`

## Requirements
- R1: Every request address is a multiple of 32 (bits 4:0 are zero). The request size `req_nsect` is 1 to 4 and stands for `req_nsect`×32 bytes.
- R2: A request never crosses a 128-byte line. The sector index (address bits 6:5) plus `req_nsect` is at most 4.
- R3: Thirty-two active lanes that read consecutive 4-byte elements starting on a 128-byte boundary produce exactly one request: the base address with `req_nsect` = 4.
- R4: The same access started 32 bytes past a line boundary produces two requests: a 96-byte request at the start address, then a 32-byte request at the next line.
- R5: Inside one line, each maximal run of touched sectors is exactly one request, starting at the run's first sector. Sectors separated by an untouched sector go out as separate requests.
- R6: Requests leave in strictly ascending address order within an instruction, whatever the order of addresses across lanes.
- R7: Inactive lanes add no sectors. An instruction with no active lanes produces no request, and `done` is high in the cycle right after it is accepted.
- R8: `in_ready` is low from the cycle after an instruction is accepted until `done` rises. It is high in the cycle `done` is high.
- R9: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_nsect` hold their values. Exactly one request is consumed per cycle in which both are high.
- R10: `done` is a single-cycle pulse, high in the cycle after the last request of an instruction is accepted.
- R11: While `rst_n` is low at a clock edge, the block returns to idle: `in_ready` high, `req_valid` low and `done` low from the next cycle on. This applies even in the middle of an instruction.
- R12: Lanes that touch the same sector, including lanes with identical addresses, share one request for that sector. Eight consecutive 4-byte elements inside one sector give a single 32-byte request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block is idle and takes an instruction |
| in_active | input | LANES | Per-lane active bit |
| in_addr | input | LANES×ADDR_W | Per-lane byte address, lane i in bits [i×ADDR_W +: ADDR_W] |
| req_valid | output | 1 | A read request is presented |
| req_ready | input | 1 | Downstream takes the request |
| req_addr | output | ADDR_W | Sector-aligned request start address |
| req_nsect | output | log2(LINE_BYTES/SECTOR_BYTES)+1 | Request length in sectors |
| done | output | 1 | One-cycle pulse when the instruction is fully issued |

## Verification
The checker assumes that the downstream side lowers `req_ready` only as a stall and never withdraws a request itself. It also assumes that `in_valid` is offered only while the block reports ready, so that an instruction is never half-accepted. The bench drives an instruction only when `in_ready` is seen high, and drops `in_valid` in the cycle after acceptance. Its stall patterns change `req_ready` at the falling edge only. Stimulus includes negative strides, duplicate addresses, sparse masks and an address at the top of the space, so that the ordering and merge properties are tested beyond simple ascending sweeps.

// File: rtl/coal_pkg.sv
// Shared types for the warp request coalescer.
// Assumes nothing beyond a standard SystemVerilog elaborator.
package coal_pkg;

    // Controller phases: waiting for input, choosing the next line, issuing runs.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_ISSUE = 2'd2
    } coal_state_e;

endpackage

// File: rtl/coal_line_min.sv
// Finds the smallest line tag among the lanes that still have pending sectors.
// Built as a binary comparison tree in heap order: node n combines nodes
// 2n+1 and 2n+2, leaves sit at N-1 .. 2N-2, and the root is node 0.
// Assumes N >= 2. Purely combinational.
module coal_line_min #(
    parameter int N     = 32,
    parameter int TAG_W = 25
) (
    input  logic [N-1:0]       pend,
    input  logic [N*TAG_W-1:0] tags,
    output logic               any_pend,
    output logic [TAG_W-1:0]   min_tag
);

    localparam int NODES = 2 * N - 1;

    logic [NODES-1:0] node_v;
    logic [TAG_W-1:0] node_t [NODES];

    genvar gi;
    generate
        // Leaves: one per lane.
        for (gi = 0; gi < N; gi++) begin : g_leaf
            assign node_v[N - 1 + gi] = pend[gi];
            assign node_t[N - 1 + gi] = tags[gi*TAG_W +: TAG_W];
        end
        // Inner nodes: keep the valid child with the lower tag.
        for (gi = 0; gi < N - 1; gi++) begin : g_node
            logic take_r;
            assign take_r = node_v[2*gi + 2] &&
                            (!node_v[2*gi + 1] || (node_t[2*gi + 2] < node_t[2*gi + 1]));
            assign node_v[gi] = node_v[2*gi + 1] | node_v[2*gi + 2];
            assign node_t[gi] = take_r ? node_t[2*gi + 2] : node_t[2*gi + 1];
        end
    endgenerate

    assign any_pend = node_v[0];
    assign min_tag  = node_t[0];

endmodule

// File: rtl/coal_sector_gather.sv
// Marks every pending lane whose line tag equals the selected tag, and ORs the
// one-hot sector positions of those lanes into a per-line sector mask.
// Assumes SECT_W = log2(SPL). Purely combinational.
module coal_sector_gather #(
    parameter int N      = 32,
    parameter int TAG_W  = 25,
    parameter int SPL    = 4,
    parameter int SECT_W = 2
) (
    input  logic [N-1:0]        pend,
    input  logic [N*TAG_W-1:0]  tags,
    input  logic [N*SECT_W-1:0] sects,
    input  logic [TAG_W-1:0]    sel_tag,
    output logic [N-1:0]        hit,
    output logic [SPL-1:0]      smask
);

    logic [SPL-1:0] lane_oh [N];

    genvar gi;
    generate
        // Per lane: match on the line tag and decode the sector position.
        for (gi = 0; gi < N; gi++) begin : g_lane
            assign hit[gi] = pend[gi] && (tags[gi*TAG_W +: TAG_W] == sel_tag);
            assign lane_oh[gi] = hit[gi] ? (SPL'(1) << sects[gi*SECT_W +: SECT_W]) : '0;
        end
    endgenerate

    // OR-reduce the per-lane sector contributions.
    always_comb begin
        smask = '0;
        for (int i = 0; i < N; i++) begin
            smask = smask | lane_oh[i];
        end
    end

endmodule

// File: rtl/coal_run_split.sv
// Picks the lowest maximal run of set bits in a line's sector mask.
// Reports the run's first sector, its length and its bit mask.
// Assumes SPL >= 2. An empty mask gives length 0. Purely combinational.
module coal_run_split #(
    parameter int SPL    = 4,
    parameter int SECT_W = 2
) (
    input  logic [SPL-1:0]    smask,
    output logic [SPL-1:0]    run_mask,
    output logic [SECT_W-1:0] run_start,
    output logic [SECT_W:0]   run_len
);

    // Walk the sectors upwards: open at the first set bit, close at the next clear bit.
    always_comb begin
        logic open_r;
        logic closed_r;
        open_r    = 1'b0;
        closed_r  = 1'b0;
        run_mask  = '0;
        run_start = '0;
        run_len   = '0;
        for (int s = 0; s < SPL; s++) begin
            if (smask[s] && !closed_r) begin
                if (!open_r) begin
                    run_start = SECT_W'(s);
                end
                open_r      = 1'b1;
                run_mask[s] = 1'b1;
                run_len     = run_len + 1'b1;
            end else if (open_r) begin
                closed_r = 1'b1;
            end
        end
    end

endmodule

// File: rtl/warp_coalescer.sv
// Warp request coalescer top.
// Captures one instruction (per-lane active bit and byte address), then walks
// the touched lines from the lowest address upwards. Each line costs one scan
// cycle. After that, each run of touched sectors in the line is issued as one
// request over a valid/ready handshake. in_ready is low while an instruction is
// in flight, and done pulses for one cycle when it is finished.
// Assumes power-of-two LINE_BYTES and SECTOR_BYTES, with SECTOR_BYTES < LINE_BYTES.
// Elements are assumed not to straddle a sector boundary.
module warp_coalescer #(
    parameter int LANES        = 32,
    parameter int ADDR_W       = 32,
    parameter int LINE_BYTES   = 128,
    parameter int SECTOR_BYTES = 32
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         in_valid,
    output logic                                         in_ready,
    input  logic [LANES-1:0]                             in_active,
    input  logic [LANES*ADDR_W-1:0]                      in_addr,
    output logic                                         req_valid,
    input  logic                                         req_ready,
    output logic [ADDR_W-1:0]                            req_addr,
    output logic [$clog2(LINE_BYTES/SECTOR_BYTES):0]     req_nsect,
    output logic                                         done
);

    import coal_pkg::*;

    localparam int SPL        = LINE_BYTES / SECTOR_BYTES;
    localparam int SECT_OFF_W = $clog2(SECTOR_BYTES);
    localparam int LINE_OFF_W = $clog2(LINE_BYTES);
    localparam int SECT_W     = LINE_OFF_W - SECT_OFF_W;
    localparam int TAG_W      = ADDR_W - LINE_OFF_W;

    coal_state_e             state_q;
    logic [LANES-1:0]        pend_q;
    logic [LANES*TAG_W-1:0]  tag_q;
    logic [LANES*SECT_W-1:0] sect_q;
    logic [TAG_W-1:0]        cur_tag_q;
    logic [SPL-1:0]          smask_q;
    logic                    done_q;

    logic [LANES*TAG_W-1:0]  lane_tag;
    logic [LANES*SECT_W-1:0] lane_sect;
    logic                    any_pend;
    logic [TAG_W-1:0]        min_tag;
    logic [LANES-1:0]        gath_hit;
    logic [SPL-1:0]          gath_mask;
    logic [SPL-1:0]          run_mask;
    logic [SECT_W-1:0]       run_start;
    logic [SECT_W:0]         run_len;
    logic [SPL-1:0]          smask_left;

    genvar gi;
    generate
        // Split each lane address into line tag and sector index; drop the byte offset.
        for (gi = 0; gi < LANES; gi++) begin : g_split
            logic unused_low;
            assign lane_tag[gi*TAG_W +: TAG_W]    = in_addr[gi*ADDR_W + LINE_OFF_W +: TAG_W];
            assign lane_sect[gi*SECT_W +: SECT_W] = in_addr[gi*ADDR_W + SECT_OFF_W +: SECT_W];
            assign unused_low = ^in_addr[gi*ADDR_W +: SECT_OFF_W];
        end
    endgenerate

    coal_line_min #(
        .N     (LANES),
        .TAG_W (TAG_W)
    ) u_min (
        .pend     (pend_q),
        .tags     (tag_q),
        .any_pend (any_pend),
        .min_tag  (min_tag)
    );

    coal_sector_gather #(
        .N      (LANES),
        .TAG_W  (TAG_W),
        .SPL    (SPL),
        .SECT_W (SECT_W)
    ) u_gather (
        .pend    (pend_q),
        .tags    (tag_q),
        .sects   (sect_q),
        .sel_tag (min_tag),
        .hit     (gath_hit),
        .smask   (gath_mask)
    );

    coal_run_split #(
        .SPL    (SPL),
        .SECT_W (SECT_W)
    ) u_split (
        .smask     (smask_q),
        .run_mask  (run_mask),
        .run_start (run_start),
        .run_len   (run_len)
    );

    // Sectors of the current line that remain after the presented run.
    assign smask_left = smask_q & ~run_mask;

    // Controller: accept, pick the next line, issue runs, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pend_q    <= '0;
            cur_tag_q <= '0;
            smask_q   <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        pend_q <= in_active;
                        if (|in_active) begin
                            state_q <= ST_SCAN;
                        end else begin
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_SCAN: begin
                    if (any_pend) begin
                        cur_tag_q <= min_tag;
                        smask_q   <= gath_mask;
                        pend_q    <= pend_q & ~gath_hit;
                        state_q   <= ST_ISSUE;
                    end else begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                ST_ISSUE: begin
                    if (req_ready) begin
                        smask_q <= smask_left;
                        if (smask_left == '0) begin
                            if (pend_q == '0) begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                            end else begin
                                state_q <= ST_SCAN;
                            end
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Lane data capture: tags and sector indices, loaded when an instruction is taken.
    always_ff @(posedge clk) begin
        if (state_q == ST_IDLE && in_valid) begin
            tag_q  <= lane_tag;
            sect_q <= lane_sect;
        end
    end

    assign in_ready  = (state_q == ST_IDLE);
    assign req_valid = (state_q == ST_ISSUE);
    assign req_addr  = {cur_tag_q, run_start, {SECT_OFF_W{1'b0}}};
    assign req_nsect = run_len;
    assign done      = done_q;

endmodule

// File: rtl/coal_checker.sv
// Protocol and shape checks for warp_coalescer, attached by bind.
// Assumes the downstream side only stalls through req_ready.
module coal_checker #(
    parameter int ADDR_W       = 32,
    parameter int LINE_BYTES   = 128,
    parameter int SECTOR_BYTES = 32
) (
    input logic                                     clk,
    input logic                                     rst_n,
    input logic                                     in_ready,
    input logic                                     req_valid,
    input logic                                     req_ready,
    input logic [ADDR_W-1:0]                        req_addr,
    input logic [$clog2(LINE_BYTES/SECTOR_BYTES):0] req_nsect,
    input logic                                     done
);

    localparam int SPL        = LINE_BYTES / SECTOR_BYTES;
    localparam int SECT_OFF_W = $clog2(SECTOR_BYTES);
    localparam int LINE_OFF_W = $clog2(LINE_BYTES);
    localparam int SECT_W     = LINE_OFF_W - SECT_OFF_W;

    logic              seen_q;
    logic [ADDR_W-1:0] last_q;

    // Track the last accepted address of the current instruction.
    always_ff @(posedge clk) begin
        if (!rst_n || done) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (req_valid && req_ready) begin
            seen_q <= 1'b1;
            last_q <= req_addr;
        end
    end

    p_sector_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[SECT_OFF_W-1:0] == '0) && (req_nsect >= 1) && (req_nsect <= SPL));

    p_no_line_cross_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ({1'b0, req_addr[LINE_OFF_W-1:SECT_OFF_W]} + (SECT_W+1)'(req_nsect) <= SPL));

    p_ascending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && seen_q) |-> (req_addr > last_q));

    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !in_ready);

    p_done_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> in_ready);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_nsect)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_reset_idle_r11: assert property (@(posedge clk)
        !rst_n |=> (in_ready && !req_valid && !done));

endmodule

bind warp_coalescer coal_checker #(
    .ADDR_W       (ADDR_W),
    .LINE_BYTES   (LINE_BYTES),
    .SECTOR_BYTES (SECTOR_BYTES)
) u_coal_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_nsect (req_nsect),
    .done      (done)
);

// File: tb/warp_coalescer_bench.sv
// Vector-table bench for warp_coalescer, followed by directed reset tests.
module warp_coalescer_bench;

    localparam int LANES = 32;
    localparam int AW    = 32;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] stride;
        logic [31:0] mask;
        logic [7:0]  nreq;
        logic [31:0] fa;
        logic [2:0]  fn;
        logic [31:0] la;
        logic [2:0]  ln;
        logic        bp;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 32'd4,          32'hFFFF_FFFF, 8'd1,  32'h0000_1000, 3'd4, 32'h0000_1000, 3'd4, 1'b0, 8'd3 },  // R3 aligned
        '{32'h0000_1020, 32'd4,          32'hFFFF_FFFF, 8'd2,  32'h0000_1020, 3'd3, 32'h0000_1080, 3'd1, 1'b1, 8'd4 },  // R4 offset split
        '{32'h0000_2000, 32'd8,          32'hFFFF_FFFF, 8'd2,  32'h0000_2000, 3'd4, 32'h0000_2080, 3'd4, 1'b0, 8'd5 },  // R5 two full lines
        '{32'h0000_0000, 32'd64,         32'hFFFF_FFFF, 8'd32, 32'h0000_0000, 3'd1, 32'h0000_07C0, 3'd1, 1'b1, 8'd5 },  // R5 gaps split runs
        '{32'h0000_0040, 32'd128,        32'hFFFF_FFFF, 8'd32, 32'h0000_0040, 3'd1, 32'h0000_0FC0, 3'd1, 1'b0, 8'd6 },  // R6 32 lines
        '{32'h0000_307C, 32'hFFFF_FFFC,  32'hFFFF_FFFF, 8'd1,  32'h0000_3000, 3'd4, 32'h0000_3000, 3'd4, 1'b0, 8'd6 },  // R6 reversed lanes
        '{32'h0000_5004, 32'd0,          32'hFFFF_FFFF, 8'd1,  32'h0000_5000, 3'd1, 32'h0000_5000, 3'd1, 1'b0, 8'd12},  // R12 duplicates
        '{32'h0000_6000, 32'd4,          32'h0000_00FF, 8'd1,  32'h0000_6000, 3'd1, 32'h0000_6000, 3'd1, 1'b0, 8'd12},  // R12 eight per sector
        '{32'h0000_7000, 32'd4,          32'h00FF_00FF, 8'd2,  32'h0000_7000, 3'd1, 32'h0000_7040, 3'd1, 1'b0, 8'd7 },  // R7 sparse mask
        '{32'h0000_9000, 32'd4,          32'h0000_0000, 8'd0,  32'h0000_0000, 3'd0, 32'h0000_0000, 3'd0, 1'b0, 8'd7 },  // R7 no lanes
        '{32'h0000_0FF0, 32'd32,         32'hFFFF_FFFF, 8'd9,  32'h0000_0FE0, 3'd1, 32'h0000_1380, 3'd3, 1'b1, 8'd5 },  // R5 nine requests
        '{32'hFFFF_FF80, 32'd4,          32'hFFFF_FFFF, 8'd1,  32'hFFFF_FF80, 3'd4, 32'hFFFF_FF80, 3'd4, 1'b0, 8'd3 }   // R3 top of space
    };

    logic                  clk;
    logic                  rst_n;
    logic                  in_valid;
    logic                  in_ready;
    logic [LANES-1:0]      in_active;
    logic [LANES*AW-1:0]   in_addr;
    logic                  req_valid;
    logic                  req_ready;
    logic [AW-1:0]         req_addr;
    logic [2:0]            req_nsect;
    logic                  done;

    int n_checks;
    int n_fail;

    warp_coalescer u_warp_coalescer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_active (in_active),
        .in_addr   (in_addr),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_nsect (req_nsect),
        .done      (done)
    );

    // 125 MHz clock: 8 ns period.
    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Offer one instruction, collect its requests, and check them against the vector.
    task automatic run_vec(input vec_t v, input int idx);
        int          cnt;
        logic [31:0] fa, la, prev;
        logic [2:0]  fn, ln;
        bit          fmt_bad, cross_bad, order_bad, busy_bad, hold_bad, hold_pend, got_done;
        logic [31:0] hold_a;
        logic [2:0]  hold_n;
        cnt = 0; fa = 0; la = 0; prev = 0; fn = 0; ln = 0;
        fmt_bad = 0; cross_bad = 0; order_bad = 0; busy_bad = 0; hold_bad = 0;
        hold_pend = 0; got_done = 0; hold_a = 0; hold_n = 0;
        @(negedge clk);
        for (int k = 0; k < LANES; k++) begin
            in_addr[k*AW +: AW] = v.base + v.stride * k;
        end
        in_active = v.mask;
        in_valid  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        for (int cyc = 0; cyc < 400; cyc++) begin
            req_ready = v.bp ? ((cyc % 3) != 0) : 1'b1;
            #1;
            if (hold_pend && (!req_valid || req_addr != hold_a || req_nsect != hold_n)) hold_bad = 1;
            hold_pend = 0;
            if (done) begin
                got_done = 1;
                break;
            end
            if (in_ready) busy_bad = 1;
            if (req_valid && req_ready) begin
                if (req_addr[4:0] != 0 || req_nsect < 1 || req_nsect > 4) fmt_bad = 1;
                if ({1'b0, req_addr[6:5]} + req_nsect > 3'd4) cross_bad = 1;
                if (cnt > 0 && req_addr <= prev) order_bad = 1;
                if (cnt == 0) begin fa = req_addr; fn = req_nsect; end
                la = req_addr; ln = req_nsect; prev = req_addr;
                cnt++;
            end else if (req_valid) begin
                hold_pend = 1; hold_a = req_addr; hold_n = req_nsect;
            end
            @(negedge clk);
        end
        chk(got_done, "R10", $sformatf("vec %0d done seen", idx), 32'(got_done), 1);
        chk(in_ready, "R8", $sformatf("vec %0d in_ready with done", idx), 32'(in_ready), 1);
        chk(cnt == int'(v.nreq), $sformatf("R%0d", v.rq), $sformatf("vec %0d request count", idx), cnt, 32'(v.nreq));
        if (v.nreq != 0) begin
            chk(fa == v.fa && fn == v.fn, $sformatf("R%0d", v.rq), $sformatf("vec %0d first addr/len", idx), fa, v.fa);
            chk(la == v.la && ln == v.ln, $sformatf("R%0d", v.rq), $sformatf("vec %0d last addr/len", idx), la, v.la);
            chk(!fmt_bad, "R1", $sformatf("vec %0d sector format", idx), 32'(fmt_bad), 0);
            chk(!cross_bad, "R2", $sformatf("vec %0d line crossing", idx), 32'(cross_bad), 0);
            chk(!order_bad, "R6", $sformatf("vec %0d ascending order", idx), 32'(order_bad), 0);
            chk(!busy_bad, "R8", $sformatf("vec %0d ready low while busy", idx), 32'(busy_bad), 0);
        end else begin
            chk(busy_bad == 0 && cnt == 0, "R7", $sformatf("vec %0d immediate done", idx), cnt, 0);
        end
        if (v.bp) chk(!hold_bad, "R9", $sformatf("vec %0d hold under stall", idx), 32'(hold_bad), 0);
        @(negedge clk);
        chk(!done, "R10", $sformatf("vec %0d done single cycle", idx), 32'(done), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        n_checks  = 0;
        n_fail    = 0;
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_active = '0;
        in_addr   = '0;
        req_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk(in_ready && !req_valid && !done, "R11", "reset state",
            {29'd0, in_ready, req_valid, done}, 32'h4);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            run_vec(VECS[v], v);
        end

        // R11: reset in the middle of a long instruction.
        @(negedge clk);
        for (int k = 0; k < LANES; k++) in_addr[k*AW +: AW] = 32'h40 + 32'd128 * k;
        in_active = '1;
        in_valid  = 1'b1;
        req_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(req_valid && !in_ready, "R9", "stalled request stays valid",
            {30'd0, req_valid, in_ready}, 32'h2);
        rst_n = 1'b0;
        @(negedge clk);
        chk(in_ready && !req_valid && !done, "R11", "mid-run reset returns idle",
            {29'd0, in_ready, req_valid, done}, 32'h4);
        rst_n = 1'b1;
        req_ready = 1'b1;
        repeat (2) @(negedge clk);
        chk(!req_valid && !done, "R11", "no leftover requests after reset",
            {30'd0, req_valid, done}, 0);

        // R3: recovery after reset with an aligned access.
        run_vec(VECS[0], 100);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule